// File: doc/BRIEF.md
# DDR Mode Register Load Sequencer

This block issues the mode-register programming steps that a DDR SDRAM controller runs before the device may return read data. When a start request arrives it captures two settings: whether the delay-locked loop is to be turned on or off, and which output drive strength to use. It then writes the extended mode register. If the loop is being turned on, a load to the base mode register with the loop-reset bit set follows. The block then holds read permission back until the loop has had enough clock-enabled cycles to lock.

Each register load is issued only when the controller reports that every bank is idle and that no burst is in flight. Otherwise the load waits. After every load the block drives no-operation commands for a programmable settling time. The controller gives the block the command bus while `busy_o` is high. It then uses `rd_ok_o` to decide when a READ may go out. Address width, settling time, lock length, base register contents and the position of the reset bit are all parameters.

Top module: `modereg_load_seq`

## Requirements
- R1: While reset is applied, the block drives the no-operation code 3'b111 on `cmd_o`, zero on `ba_o` and `addr_o`, and holds both `busy_o` and `rd_ok_o` low.
- R2: A start request sampled while `busy_o` is low is accepted. In the next cycle `busy_o` is high and `rd_ok_o` is low.
- R3: The first command after acceptance is the load code 3'b000 ({ras_n, cas_n, we_n}) with `ba_o` = 2'b01. Its address has bit 0 = 1 when the loop is to be disabled (`dll_en_i` = 0) and 0 when enabled, bit 1 = the drive-strength select, and every higher bit 0.
- R4: A load is never issued while `idle_i` is low. A pending load appears on `cmd_o` in the cycle after `idle_i` is first sampled high, and until then `cmd_o` shows 3'b111.
- R5: Every load is followed by exactly TMRD cycles of 3'b111 on `cmd_o` before the next step starts, and `busy_o` stays high through them.
- R6: When the loop is enabled, the next load after the extended write goes to `ba_o` = 2'b00. Its address is the base-register parameter with bit DLL_RST_BIT forced to 1.
- R7: After the base load, `rd_ok_o` rises and `busy_o` falls together once LOCK_CYCLES consecutive cycles have had `cke_i` sampled high. The first of those cycles is the base-load cycle, and a cycle with `cke_i` low restarts the count.
- R8: When the loop is disabled, no base load is issued. `busy_o` falls and `rd_ok_o` rises in the cycle after the TMRD settling cycles.
- R9: Start requests sampled while `busy_o` is high have no effect: no extra load appears and the running sequence keeps its timing.
- R10: `dll_en_i` and `drv_i` are captured when the start is accepted. Changes to them while `busy_o` is high do not alter the loads.
- R11: After completion, `rd_ok_o` stays high and `busy_o` low until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run the programming sequence |
| dll_en_i | input | 1 | 1 = turn the delay-locked loop on, 0 = turn it off |
| drv_i | input | 1 | Output drive-strength select, 0 = normal |
| idle_i | input | 1 | All banks idle and no burst in flight |
| cke_i | input | 1 | Clock-enable level currently driven to the device |
| cmd_o | output | 3 | Command code {ras_n, cas_n, we_n} |
| ba_o | output | 2 | Bank address, bit 0 = BA0 |
| addr_o | output | ADDR_W | Address bus carrying the register contents |
| busy_o | output | 1 | Sequence running and command bus owned |
| rd_ok_o | output | 1 | READ commands may be issued |

## Verification
The hardest state to reach is a lock count restarted by a low `cke_i` partway through the window, with the hold-off on `idle_i` and stray start pulses landing in the same run. The stimulus drops `cke_i` with a small random probability during the lock phase and tracks the expected run length cycle by cycle. It stretches each pending load with a random number of non-idle cycles, and it pulses `start_i` and flips the captured settings while the sequence is busy. Directed runs cover the disabled-loop path and an uninterrupted 200-cycle lock.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

   typedef enum logic [2:0] {
      CMD_LMR = 3'b000,
      CMD_NOP = 3'b111
   } mrs_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_EXT_HOLD = 3'd1,
      ST_EXT_WAIT = 3'd2,
      ST_MR_HOLD  = 3'd3,
      ST_LOCK     = 3'd4
   } mrs_state_e;

   localparam logic [1:0] BA_BASE_REG = 2'b00;
   localparam logic [1:0] BA_EXT_REG  = 2'b01;

endpackage

// File: rtl/mrs_cycle_counter.sv
module mrs_cycle_counter #(
   parameter int LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic hit_o
);
   localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

   generate
      if (LIMIT == 0) begin : g_zero
         assign hit_o = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr_i) begin
               cnt_q <= '0;
            end else if (inc_i && (cnt_q != CW'(LIMIT))) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign hit_o = (cnt_q == CW'(LIMIT));
      end
   endgenerate

endmodule

// File: rtl/mrs_word_builder.sv
module mrs_word_builder #(
   parameter int          ADDR_W      = 14,
   parameter int          DLL_RST_BIT = 8,
   parameter logic [15:0] BASE_WORD   = 16'h0021
) (
   input  logic              dll_en_i,
   input  logic              drv_i,
   output logic [ADDR_W-1:0] ext_word_o,
   output logic [ADDR_W-1:0] base_word_o
);
   localparam logic [ADDR_W-1:0] RST_MASK = {{(ADDR_W-1){1'b0}}, 1'b1} << DLL_RST_BIT;

   // low control field of the extended register
   assign ext_word_o[0] = ~dll_en_i;
   assign ext_word_o[1] = drv_i;

   // operating-mode field: always zero, width follows ADDR_W
   generate
      for (genvar b = 2; b < ADDR_W; b++) begin : g_opmode
         assign ext_word_o[b] = 1'b0;
      end
   endgenerate

   assign base_word_o = BASE_WORD[ADDR_W-1:0] | RST_MASK;

endmodule

// File: rtl/mrs_fsm.sv
module mrs_fsm
   import mrs_pkg::*;
#(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dll_en_i,
   input  logic              drv_i,
   input  logic              idle_i,
   input  logic              cke_i,
   input  logic              settle_hit_i,
   input  logic              lock_hit_i,
   input  logic [ADDR_W-1:0] ext_word_i,
   input  logic [ADDR_W-1:0] base_word_i,
   output logic              dll_en_q_o,
   output logic              drv_q_o,
   output logic              settle_clr_o,
   output logic              settle_inc_o,
   output logic              lock_clr_o,
   output logic              lock_inc_o,
   output logic [2:0]        cmd_o,
   output logic [1:0]        ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              busy_o,
   output logic              rd_ok_o
);
   mrs_state_e        state_q;
   mrs_cmd_e          cmd_q;
   logic [1:0]        ba_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_ok_q;
   logic              dll_en_q;
   logic              drv_q;

   logic ext_go;
   logic base_go;

   assign ext_go  = (state_q == ST_EXT_HOLD) && idle_i;
   assign base_go = (state_q == ST_MR_HOLD) && idle_i;

   assign settle_clr_o = ext_go;
   assign settle_inc_o = (state_q == ST_EXT_WAIT);
   assign lock_clr_o   = base_go || ((state_q == ST_LOCK) && !cke_i);
   assign lock_inc_o   = (state_q == ST_LOCK) && cke_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cmd_q    <= CMD_NOP;
         ba_q     <= '0;
         addr_q   <= '0;
         rd_ok_q  <= 1'b0;
         dll_en_q <= 1'b1;
         drv_q    <= 1'b0;
      end else begin
         cmd_q  <= CMD_NOP;
         ba_q   <= '0;
         addr_q <= '0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q  <= ST_EXT_HOLD;
                  rd_ok_q  <= 1'b0;
                  dll_en_q <= dll_en_i;
                  drv_q    <= drv_i;
               end
            end
            ST_EXT_HOLD: begin
               if (ext_go) begin
                  cmd_q   <= CMD_LMR;
                  ba_q    <= BA_EXT_REG;
                  addr_q  <= ext_word_i;
                  state_q <= ST_EXT_WAIT;
               end
            end
            ST_EXT_WAIT: begin
               if (settle_hit_i) begin
                  if (dll_en_q) begin
                     state_q <= ST_MR_HOLD;
                  end else begin
                     state_q <= ST_IDLE;
                     rd_ok_q <= 1'b1;
                  end
               end
            end
            ST_MR_HOLD: begin
               if (base_go) begin
                  cmd_q   <= CMD_LMR;
                  ba_q    <= BA_BASE_REG;
                  addr_q  <= base_word_i;
                  state_q <= ST_LOCK;
               end
            end
            ST_LOCK: begin
               if (cke_i && lock_hit_i) begin
                  state_q <= ST_IDLE;
                  rd_ok_q <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dll_en_q_o = dll_en_q;
   assign drv_q_o    = drv_q;
   assign cmd_o      = cmd_q;
   assign ba_o       = ba_q;
   assign addr_o     = addr_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign rd_ok_o    = rd_ok_q;

endmodule

// File: rtl/modereg_load_seq.sv
module modereg_load_seq #(
   parameter int          ADDR_W      = 14,
   parameter int          TMRD        = 2,
   parameter int          LOCK_CYCLES = 200,
   parameter int          DLL_RST_BIT = 8,
   parameter logic [15:0] BASE_WORD   = 16'h0021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dll_en_i,
   input  logic              drv_i,
   input  logic              idle_i,
   input  logic              cke_i,
   output logic [2:0]        cmd_o,
   output logic [1:0]        ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              busy_o,
   output logic              rd_ok_o
);
   localparam int LOCK_LAST = LOCK_CYCLES - 1;

   generate
      if ((ADDR_W < 14) || (ADDR_W > 16)) begin : g_bad_aw
         $error("modereg_load_seq: ADDR_W must be 14, 15 or 16");
      end
      if (TMRD < 1) begin : g_bad_tmrd
         $error("modereg_load_seq: TMRD must be at least 1");
      end
      if ((LOCK_CYCLES < 2) || (LOCK_CYCLES <= TMRD)) begin : g_bad_lock
         $error("modereg_load_seq: LOCK_CYCLES must be at least 2 and above TMRD");
      end
      if ((DLL_RST_BIT < 2) || (DLL_RST_BIT >= ADDR_W)) begin : g_bad_rst
         $error("modereg_load_seq: DLL_RST_BIT out of range");
      end
   endgenerate

   logic              dll_en_q;
   logic              drv_q;
   logic [ADDR_W-1:0] ext_word;
   logic [ADDR_W-1:0] base_word;
   logic              settle_clr;
   logic              settle_inc;
   logic              settle_hit;
   logic              lock_clr;
   logic              lock_inc;
   logic              lock_hit;

   mrs_word_builder #(
      .ADDR_W      (ADDR_W),
      .DLL_RST_BIT (DLL_RST_BIT),
      .BASE_WORD   (BASE_WORD)
   ) words_i (
      .dll_en_i    (dll_en_q),
      .drv_i       (drv_q),
      .ext_word_o  (ext_word),
      .base_word_o (base_word)
   );

   mrs_cycle_counter #(.LIMIT(TMRD)) settle_cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (settle_clr),
      .inc_i (settle_inc),
      .hit_o (settle_hit)
   );

   mrs_cycle_counter #(.LIMIT(LOCK_LAST)) lock_cnt_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (lock_clr),
      .inc_i (lock_inc),
      .hit_o (lock_hit)
   );

   mrs_fsm #(.ADDR_W(ADDR_W)) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .dll_en_i     (dll_en_i),
      .drv_i        (drv_i),
      .idle_i       (idle_i),
      .cke_i        (cke_i),
      .settle_hit_i (settle_hit),
      .lock_hit_i   (lock_hit),
      .ext_word_i   (ext_word),
      .base_word_i  (base_word),
      .dll_en_q_o   (dll_en_q),
      .drv_q_o      (drv_q),
      .settle_clr_o (settle_clr),
      .settle_inc_o (settle_inc),
      .lock_clr_o   (lock_clr),
      .lock_inc_o   (lock_inc),
      .cmd_o        (cmd_o),
      .ba_o         (ba_o),
      .addr_o       (addr_o),
      .busy_o       (busy_o),
      .rd_ok_o      (rd_ok_o)
   );

endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
   parameter int ADDR_W      = 14,
   parameter int TMRD        = 2,
   parameter int LOCK_CYCLES = 200,
   parameter int DLL_RST_BIT = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              idle_i,
   input logic              cke_i,
   input logic [2:0]        cmd_o,
   input logic [1:0]        ba_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              busy_o,
   input logic              rd_ok_o
);
   localparam int GW = $clog2(TMRD + 2);
   localparam int RW = $clog2(LOCK_CYCLES + 1);

   logic          is_load;
   logic          is_ext;
   logic          is_base;
   logic [GW-1:0] gap_q;
   logic          seen_load_q;
   logic          ext_en_q;
   logic          lock_pend_q;
   logic [RW-1:0] run_q;

   assign is_load = (cmd_o == 3'b000);
   assign is_ext  = is_load && (ba_o == 2'b01);
   assign is_base = is_load && (ba_o == 2'b00);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q       <= '0;
         seen_load_q <= 1'b0;
         ext_en_q    <= 1'b0;
         lock_pend_q <= 1'b0;
         run_q       <= '0;
      end else begin
         if (is_load) begin
            gap_q       <= '0;
            seen_load_q <= 1'b1;
         end else if (gap_q != GW'(TMRD + 1)) begin
            gap_q <= gap_q + 1'b1;
         end
         if (is_ext) ext_en_q <= !addr_o[0];
         else if (is_base) ext_en_q <= 1'b0;
         if (is_base) lock_pend_q <= 1'b1;
         else if (rd_ok_o) lock_pend_q <= 1'b0;
         if (is_base) run_q <= cke_i ? RW'(1) : '0;
         else if (!cke_i) run_q <= '0;
         else if (run_q != RW'(LOCK_CYCLES)) run_q <= run_q + 1'b1;
      end
   end

   // R1 / R3 / R6: only the two defined command codes appear
   a_r1_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 3'b000) || (cmd_o == 3'b111));

   a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i) |=> (busy_o && !rd_ok_o));

   a_r3_ext_opmode_zero: assert property (@(posedge clk) disable iff (!rst_n)
      is_ext |-> (addr_o[ADDR_W-1:2] == '0));

   a_r4_load_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |-> $past(idle_i));

   a_r5_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (is_load && seen_load_q) |-> (gap_q >= GW'(TMRD)));

   a_r5_nop_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |=> (cmd_o == 3'b111) && busy_o);

   a_r6_base_reset_bit: assert property (@(posedge clk) disable iff (!rst_n)
      is_base |-> addr_o[DLL_RST_BIT]);

   a_r6_base_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      is_base |-> ext_en_q);

   a_r7_lock_window: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_ok_o) && lock_pend_q) |-> (run_q >= RW'(LOCK_CYCLES)));

   a_r11_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !rd_ok_o);

endmodule

bind modereg_load_seq mrs_checker #(
   .ADDR_W      (ADDR_W),
   .TMRD        (TMRD),
   .LOCK_CYCLES (LOCK_CYCLES),
   .DLL_RST_BIT (DLL_RST_BIT)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .idle_i  (idle_i),
   .cke_i   (cke_i),
   .cmd_o   (cmd_o),
   .ba_o    (ba_o),
   .addr_o  (addr_o),
   .busy_o  (busy_o),
   .rd_ok_o (rd_ok_o)
);

// File: tb/modereg_load_seq_tb_top.sv
module modereg_load_seq_tb_top;
   localparam int          AW = 14;
   localparam int          TM = 2;
   localparam int          LK = 200;
   localparam int          RB = 8;
   localparam logic [15:0] BW = 16'h0021;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          dll_en_i = 1'b0;
   logic          drv_i = 1'b0;
   logic          idle_i = 1'b0;
   logic          cke_i = 1'b1;
   logic [2:0]    cmd_o;
   logic [1:0]    ba_o;
   logic [AW-1:0] addr_o;
   logic          busy_o;
   logic          rd_ok_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   modereg_load_seq #(
      .ADDR_W(AW), .TMRD(TM), .LOCK_CYCLES(LK), .DLL_RST_BIT(RB), .BASE_WORD(BW)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dll_en_i(dll_en_i),
      .drv_i(drv_i), .idle_i(idle_i), .cke_i(cke_i), .cmd_o(cmd_o),
      .ba_o(ba_o), .addr_o(addr_o), .busy_o(busy_o), .rd_ok_o(rd_ok_o)
   );

   function automatic logic [AW-1:0] ext_exp(input bit en, input bit drv);
      logic [AW-1:0] w;
      w    = '0;
      w[0] = ~en;
      w[1] = drv;
      return w;
   endfunction

   function automatic logic [AW-1:0] base_exp();
      logic [AW-1:0] w;
      w     = BW[AW-1:0];
      w[RB] = 1'b1;
      return w;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_wait(input string req, input string what);
      chk(cmd_o == 3'b111, req, {what, " cmd"}, cmd_o, 3'b111);
      chk(busy_o == 1'b1 && rd_ok_o == 1'b0, req, {what, " busy/rd_ok"},
          {busy_o, rd_ok_o}, 2'b10);
   endtask

   task automatic run_seq(input bit en, input bit drv, input int d1, input int d2,
                          input bit poke, input bit flip, input int low_pct);
      int run;
      bit prev;
      @(negedge clk);
      start_i = 1'b1; dll_en_i = en; drv_i = drv; idle_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o && !rd_ok_o, "R2", "accept", {busy_o, rd_ok_o}, 2'b10);
      if (flip) begin dll_en_i = ~en; drv_i = ~drv; end  // R10: late changes
      for (int i = 0; i < d1; i++) begin
         idle_i = 1'b0; start_i = poke;
         @(negedge clk);
         start_i = 1'b0;
         chk_wait("R4", "ext held");
      end
      idle_i = 1'b1;
      @(negedge clk);
      chk(cmd_o == 3'b000, "R3", "ext load cmd", cmd_o, 3'b000);
      chk(ba_o == 2'b01, "R3", "ext load bank", ba_o, 2'b01);
      chk(addr_o == ext_exp(en, drv), "R3_R10", "ext word", addr_o, ext_exp(en, drv));
      for (int i = 0; i < TM; i++) begin
         idle_i = 1'($urandom_range(0, 1)); start_i = poke;  // R9: ignored
         @(negedge clk);
         chk_wait("R5", "ext settle");
      end
      start_i = 1'b0; idle_i = 1'b0;
      @(negedge clk);
      if (!en) begin
         chk(!busy_o && rd_ok_o, "R8", "disabled finish", {busy_o, rd_ok_o}, 2'b01);
         chk(cmd_o == 3'b111, "R8", "no base load", cmd_o, 3'b111);
      end else begin
         chk_wait("R6", "base pending");
         for (int i = 0; i < d2; i++) begin
            idle_i = 1'b0;
            @(negedge clk);
            chk_wait("R4", "base held");
         end
         idle_i = 1'b1;
         @(negedge clk);
         chk(cmd_o == 3'b000, "R6", "base load cmd", cmd_o, 3'b000);
         chk(ba_o == 2'b00, "R6", "base load bank", ba_o, 2'b00);
         chk(addr_o == base_exp(), "R6", "base word", addr_o, base_exp());
         idle_i = 1'($urandom_range(0, 1));
         prev = ($urandom_range(0, 99) >= low_pct);
         cke_i = prev;
         run = 0;
         for (int k = 0; k < 1000; k++) begin
            start_i = (poke && ($urandom_range(0, 7) == 0));
            @(negedge clk);
            start_i = 1'b0;
            run = prev ? run + 1 : 0;
            if (run == LK) begin
               chk(!busy_o && rd_ok_o, "R7", "lock done", {busy_o, rd_ok_o}, 2'b01);
               break;
            end
            chk_wait("R7", "lock wait");
            prev = (k > 500) || ($urandom_range(0, 99) >= low_pct);
            cke_i = prev;
         end
      end
      cke_i = 1'b1;
      for (int i = 0; i < 3; i++) begin
         idle_i = 1'($urandom_range(0, 1));
         @(negedge clk);
         chk(!busy_o && rd_ok_o && cmd_o == 3'b111, "R11", "ready hold",
             {busy_o, rd_ok_o, cmd_o}, 5'b01111);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240917));
      start_i = 1'b1;  // requests during reset must be ignored
      repeat (3) @(negedge clk);
      chk(cmd_o == 3'b111 && ba_o == 2'b00 && addr_o == '0, "R1", "reset bus",
          {cmd_o, ba_o}, 5'b11100);
      chk(!busy_o && !rd_ok_o, "R1", "reset flags", {busy_o, rd_ok_o}, 2'b00);
      start_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !rd_ok_o && cmd_o == 3'b111, "R1", "after release",
          {busy_o, rd_ok_o, cmd_o}, 5'b00111);

      run_seq(1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 0);   // enable, steady CKE
      run_seq(1'b0, 1'b1, 2, 0, 1'b1, 1'b1, 0);   // disable path, late flips
      run_seq(1'b1, 1'b1, 3, 2, 1'b1, 1'b1, 4);   // CKE dropouts
      run_seq(1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 0);
      for (int r = 0; r < 8; r++) begin
         run_seq(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 4), $urandom_range(0, 4),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 3));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule